// File: doc/BRIEF.md
# Daisy-Chain Enumeration Sequencer

This block finds out how many monitoring devices are connected in a serial daisy chain. After a `start` request it sends a fixed series of broadcast register writes through a 32-bit word-transfer port. The first two writes reset the chain and release it with its addresses locked and readback relayed down the chain. The third write points every device's readback pointer at the low control register. The block then clocks out readback words one by one. Each device answers with one word that carries its own address. The first all-zero word marks the end of the chain.

Frame building and CRC checking are left to a companion codec. The sequencer puts out the fields of the write it wants (device address, register, value, broadcast flag) and sends back the frame the codec returns. For every readback word it presents the received word and reads back one CRC-ok bit. The physical serial link sits behind the transfer port. Each word is one `xfer_start` pulse followed by a `xfer_done` pulse.

States: `ST_IDLE`, `ST_RST_SEND`/`ST_RST_WAIT` (reset write), `ST_RUN_SEND`/`ST_RUN_WAIT` (release write), `ST_PTR_SEND`/`ST_PTR_WAIT` (pointer write), `ST_RD_SEND`/`ST_RD_WAIT` (one readback word), `ST_EVAL` (judge the word), `ST_PD_SEND`/`ST_PD_WAIT` (power-down write on error), `ST_DONE`. Transitions:
- idle goes to reset on `start`.
- Each SEND state goes to its WAIT state.
- Each WAIT state goes on when `xfer_done` arrives.
- Eval goes back to readback for the next index.
- Eval goes to done on a terminator.
- Eval goes to power-down on any error.
- Power-down goes to done.
- Done goes to idle.

Top module: `enum_chain_sequencer`

## Requirements
- R1: After reset the block is idle: `xfer_start` and `done` are low, and `dev_count` and `err` are 0.
- R2: A scan begins with two broadcast writes (device address 0, broadcast flag 1) to register 0x0E. The first carries value 0x95 (reset bit 7, must-set bit 4, address-lock bit 2, chain-readback bit 0). The second carries value 0x15, which is the same with the reset bit clear.
- R3: The third write is a broadcast write of value 0x38 to register 0x1C. This value places the pointer 0x0E in field bits 7:2.
- R4: Every readback word sends the fixed word 0xF800030A. A new transfer starts only after the previous one has signalled done. At most MAX_DEVS+1 (nine) readback words are sent per scan.
- R5: If readback word n (counting from 0) is all zero and n is at least 1, the scan ends with `err`=0 and `dev_count`=n−1. No power-down write is sent.
- R6: A non-zero word whose CRC is reported bad on `chk_ok` ends the scan with `err`=1. The all-zero test is made before the CRC test.
- R7: A non-zero word with a good CRC ends the scan with `err`=2 when its address field (bits 31:27, least significant bit sent first), read bit-reversed, is not equal to n.
- R8: The scan ends with `err`=3 when word 0 is all zero, or when nine valid non-zero words arrive with no terminator.
- R9: Every error outcome sends one broadcast write of value 0x01 (power-down) to register 0x0D before `done`.
- R10: `done` is a single-cycle pulse. `dev_count` and `err` keep their values after it until the next accepted `start`.
- R11: A `start` pulse while a scan is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Scan request, taken only when idle |
| done | output | 1 | One-cycle end-of-scan pulse |
| dev_count | output | 3 | Number of devices after the first |
| err | output | 2 | 0 ok, 1 CRC, 2 address, 3 chain fault |
| xfer_start | output | 1 | Word transfer request pulse |
| xfer_tx | output | 32 | Word to send, valid with `xfer_start` |
| xfer_rx | input | 32 | Received word, valid with `xfer_done` |
| xfer_done | input | 1 | Transfer complete pulse |
| cmd_dev | output | 5 | Device address of the requested write |
| cmd_reg | output | 6 | Register address of the requested write |
| cmd_val | output | 8 | Value of the requested write |
| cmd_all | output | 1 | Broadcast flag of the requested write |
| enc_frame | input | 32 | Encoded frame from the codec |
| chk_word | output | 32 | Last readback word, for CRC check |
| chk_ok | input | 1 | Codec verdict on `chk_word` |

## Verification
The bench goes after the edges of the scan:
- A terminator on the very first word. A design that reports a count there instead of a fault would give a wrapped count of 7.
- A full chain of eight devices, and a ninth valid word with no terminator. An off-by-one in the word limit would either cut the chain short or read a tenth word.
- A bad CRC or a wrong address injected at a random index. A design that tests these in the wrong order, or that forgets the address reversal, reports the wrong error code or accepts the word. Any error path that skips the power-down write leaves one transfer missing from the log.
- A second `start` in the middle of a scan. A design that restarts on it sends the reset write again.

// File: rtl/enum_chain_pkg.sv
package enum_chain_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_SEND,
        ST_RST_WAIT,
        ST_RUN_SEND,
        ST_RUN_WAIT,
        ST_PTR_SEND,
        ST_PTR_WAIT,
        ST_RD_SEND,
        ST_RD_WAIT,
        ST_EVAL,
        ST_PD_SEND,
        ST_PD_WAIT,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_CRC   = 2'd1,
        ERR_ADDR  = 2'd2,
        ERR_CHAIN = 2'd3
    } scan_err_t;

    typedef enum logic [1:0] {
        CMD_RESET,
        CMD_RELEASE,
        CMD_POINT,
        CMD_POWERDOWN
    } cmd_sel_t;

    // register addresses seen by every device in the chain
    localparam logic [5:0] REG_CTRL_HI  = 6'h0D;
    localparam logic [5:0] REG_CTRL_LO  = 6'h0E;
    localparam logic [5:0] REG_READ_PTR = 6'h1C;

    // low control register bit positions
    localparam int LO_SWRST_BIT = 7;
    localparam int LO_MUST_BIT  = 4;
    localparam int LO_LOCK_BIT  = 2;
    localparam int LO_RDBK_BIT  = 0;

    localparam logic [7:0] LO_RUN_VAL =
        8'((1 << LO_MUST_BIT) | (1 << LO_LOCK_BIT) | (1 << LO_RDBK_BIT));
    localparam logic [7:0] LO_RESET_VAL = LO_RUN_VAL | 8'(1 << LO_SWRST_BIT);

    // read pointer field sits at bits 7:2
    localparam logic [7:0] PTR_VAL = {REG_CTRL_LO, 2'b00};

    // high control register: software power-down in bit 0
    localparam logic [7:0] HI_PWRDN_VAL = 8'h01;

endpackage

// File: rtl/enum_cmd_select.sv
module enum_cmd_select
    import enum_chain_pkg::*;
#(
    parameter int DEV_W = 5,
    parameter int REG_W = 6,
    parameter int VAL_W = 8
) (
    input  cmd_sel_t          sel,
    output logic [DEV_W-1:0]  dev,
    output logic [REG_W-1:0]  regaddr,
    output logic [VAL_W-1:0]  val,
    output logic              all
);

    always_comb begin
        dev = '0;
        all = 1'b1;
        unique case (sel)
            CMD_RESET: begin
                regaddr = REG_W'(REG_CTRL_LO);
                val     = VAL_W'(LO_RESET_VAL);
            end
            CMD_RELEASE: begin
                regaddr = REG_W'(REG_CTRL_LO);
                val     = VAL_W'(LO_RUN_VAL);
            end
            CMD_POINT: begin
                regaddr = REG_W'(REG_READ_PTR);
                val     = VAL_W'(PTR_VAL);
            end
            CMD_POWERDOWN: begin
                regaddr = REG_W'(REG_CTRL_HI);
                val     = VAL_W'(HI_PWRDN_VAL);
            end
            default: begin
                regaddr = '0;
                val     = '0;
            end
        endcase
    end

endmodule

// File: rtl/enum_word_eval.sv
module enum_word_eval #(
    parameter int WORD_W   = 32,
    parameter int DEV_W    = 5,
    parameter int IDX_W    = 4,
    parameter int ADDR_LSB = 27
) (
    input  logic [WORD_W-1:0] word,
    input  logic [IDX_W-1:0]  idx,
    output logic              is_zero,
    output logic              addr_match
);

    logic [DEV_W-1:0] field;
    logic [DEV_W-1:0] logical;

    assign field = word[ADDR_LSB +: DEV_W];

    // address travels least significant bit first: undo the mirror
    for (genvar b = 0; b < DEV_W; b++) begin : g_rev
        assign logical[b] = field[DEV_W-1-b];
    end

    assign is_zero    = (word == '0);
    assign addr_match = (logical == DEV_W'(idx));

endmodule

// File: rtl/enum_read_index.sv
module enum_read_index #(
    parameter int IDX_W = 4,
    parameter int LAST  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [IDX_W-1:0] idx,
    output logic             at_first,
    output logic             at_last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clr) begin
            idx <= '0;
        end else if (inc) begin
            idx <= idx + 1'b1;
        end
    end

    assign at_first = (idx == '0);
    assign at_last  = (idx == IDX_W'(LAST));

endmodule

// File: rtl/enum_chain_sequencer.sv
module enum_chain_sequencer
    import enum_chain_pkg::*;
#(
    parameter int          MAX_DEVS  = 8,
    parameter int          WORD_W    = 32,
    parameter int          DEV_W     = 5,
    parameter int          REG_W     = 6,
    parameter int          VAL_W     = 8,
    parameter int          ADDR_LSB  = 27,
    parameter logic [31:0] READ_WORD = 32'hF800_030A,
    localparam int         IDX_W     = $clog2(MAX_DEVS + 1),
    localparam int         CNT_W     = $clog2(MAX_DEVS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic [CNT_W-1:0]  dev_count,
    output logic [1:0]        err,
    output logic              xfer_start,
    output logic [WORD_W-1:0] xfer_tx,
    input  logic [WORD_W-1:0] xfer_rx,
    input  logic              xfer_done,
    output logic [DEV_W-1:0]  cmd_dev,
    output logic [REG_W-1:0]  cmd_reg,
    output logic [VAL_W-1:0]  cmd_val,
    output logic              cmd_all,
    input  logic [WORD_W-1:0] enc_frame,
    output logic [WORD_W-1:0] chk_word,
    input  logic              chk_ok
);

    seq_state_t        state_q, state_d;
    cmd_sel_t          sel;
    logic [WORD_W-1:0] rx_q;
    logic [IDX_W-1:0]  idx;
    logic              idx_first, idx_last;
    logic              idx_clr, idx_inc;
    logic              w_zero, w_addr_ok;
    logic              res_load;
    scan_err_t         res_err;
    scan_err_t         err_q;
    logic [CNT_W-1:0]  count_q;

    enum_cmd_select #(
        .DEV_W (DEV_W),
        .REG_W (REG_W),
        .VAL_W (VAL_W)
    ) u_cmd (
        .sel     (sel),
        .dev     (cmd_dev),
        .regaddr (cmd_reg),
        .val     (cmd_val),
        .all     (cmd_all)
    );

    enum_word_eval #(
        .WORD_W   (WORD_W),
        .DEV_W    (DEV_W),
        .IDX_W    (IDX_W),
        .ADDR_LSB (ADDR_LSB)
    ) u_eval (
        .word       (rx_q),
        .idx        (idx),
        .is_zero    (w_zero),
        .addr_match (w_addr_ok)
    );

    enum_read_index #(
        .IDX_W (IDX_W),
        .LAST  (MAX_DEVS)
    ) u_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (idx_clr),
        .inc      (idx_inc),
        .idx      (idx),
        .at_first (idx_first),
        .at_last  (idx_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and eval decision
    always_comb begin
        state_d  = state_q;
        res_load = 1'b0;
        res_err  = ERR_NONE;
        idx_inc  = 1'b0;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_RST_SEND;
            ST_RST_SEND: state_d = ST_RST_WAIT;
            ST_RST_WAIT: if (xfer_done) state_d = ST_RUN_SEND;
            ST_RUN_SEND: state_d = ST_RUN_WAIT;
            ST_RUN_WAIT: if (xfer_done) state_d = ST_PTR_SEND;
            ST_PTR_SEND: state_d = ST_PTR_WAIT;
            ST_PTR_WAIT: if (xfer_done) state_d = ST_RD_SEND;
            ST_RD_SEND:  state_d = ST_RD_WAIT;
            ST_RD_WAIT:  if (xfer_done) state_d = ST_EVAL;
            ST_EVAL: begin
                res_load = 1'b1;
                if (w_zero) begin
                    if (idx_first) begin
                        res_err = ERR_CHAIN;
                        state_d = ST_PD_SEND;
                    end else begin
                        res_err = ERR_NONE;
                        state_d = ST_DONE;
                    end
                end else if (!chk_ok) begin
                    res_err = ERR_CRC;
                    state_d = ST_PD_SEND;
                end else if (!w_addr_ok) begin
                    res_err = ERR_ADDR;
                    state_d = ST_PD_SEND;
                end else if (idx_last) begin
                    res_err = ERR_CHAIN;
                    state_d = ST_PD_SEND;
                end else begin
                    res_load = 1'b0;
                    idx_inc  = 1'b1;
                    state_d  = ST_RD_SEND;
                end
            end
            ST_PD_SEND:  state_d = ST_PD_WAIT;
            ST_PD_WAIT:  if (xfer_done) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        xfer_start = 1'b0;
        done       = 1'b0;
        idx_clr    = 1'b0;
        sel        = CMD_POWERDOWN;
        xfer_tx    = enc_frame;
        unique case (state_q)
            ST_IDLE:     idx_clr = start;
            ST_RST_SEND: begin sel = CMD_RESET;   xfer_start = 1'b1; end
            ST_RST_WAIT: sel = CMD_RESET;
            ST_RUN_SEND: begin sel = CMD_RELEASE; xfer_start = 1'b1; end
            ST_RUN_WAIT: sel = CMD_RELEASE;
            ST_PTR_SEND: begin sel = CMD_POINT;   xfer_start = 1'b1; end
            ST_PTR_WAIT: sel = CMD_POINT;
            ST_RD_SEND: begin
                xfer_start = 1'b1;
                xfer_tx    = WORD_W'(READ_WORD);
            end
            ST_RD_WAIT:  xfer_tx = WORD_W'(READ_WORD);
            ST_EVAL:     ;
            ST_PD_SEND:  xfer_start = 1'b1;
            ST_PD_WAIT:  ;
            ST_DONE:     done = 1'b1;
            default:     ;
        endcase
    end

    // capture of readback word and scan result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q    <= '0;
            err_q   <= ERR_NONE;
            count_q <= '0;
        end else begin
            if (state_q == ST_RD_WAIT && xfer_done) begin
                rx_q <= xfer_rx;
            end
            if (state_q == ST_IDLE && start) begin
                err_q   <= ERR_NONE;
                count_q <= '0;
            end else if (res_load) begin
                err_q   <= res_err;
                count_q <= (res_err == ERR_NONE) ? CNT_W'(idx - 1'b1) : '0;
            end
        end
    end

    assign chk_word  = rx_q;
    assign err       = err_q;
    assign dev_count = count_q;

endmodule

// File: rtl/enum_chain_sva.sv
module enum_chain_sva #(
    parameter int          MAX_DEVS  = 8,
    parameter int          WORD_W    = 32,
    parameter logic [31:0] READ_WORD = 32'hF800_030A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic              xfer_start,
    input logic [WORD_W-1:0] xfer_tx,
    input logic              xfer_done
);

    logic       pending;
    logic [7:0] rd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
            rd_cnt  <= '0;
        end else begin
            if (xfer_start)     pending <= 1'b1;
            else if (xfer_done) pending <= 1'b0;
            if (done)
                rd_cnt <= '0;
            else if (xfer_start && xfer_tx == WORD_W'(READ_WORD))
                rd_cnt <= rd_cnt + 1'b1;
        end
    end

    // R4: one transfer outstanding at a time
    a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !pending);

    // R4: transfer requests are single pulses
    a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    // R4: readback words per scan bounded
    a_r4_read_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= 8'(MAX_DEVS + 1));

    // R10: done lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: no transfer while reporting
    a_r10_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !xfer_start);

    // R11: a start pulse while a transfer is pending does not add a transfer
    a_r11_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && pending) |-> !xfer_start);

endmodule

bind enum_chain_sequencer enum_chain_sva #(
    .MAX_DEVS  (MAX_DEVS),
    .WORD_W    (WORD_W),
    .READ_WORD (READ_WORD)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .done       (done),
    .xfer_start (xfer_start),
    .xfer_tx    (xfer_tx),
    .xfer_done  (xfer_done)
);

// File: tb/test_enum_chain_sequencer.sv
`timescale 1ns/1ps
module test_enum_chain_sequencer;

    localparam logic [31:0] RDW = 32'hF800_030A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        done;
    logic [2:0]  dev_count;
    logic [1:0]  err;
    logic        xfer_start;
    logic [31:0] xfer_tx;
    logic [31:0] xfer_rx = '0;
    logic        xfer_done = 1'b0;
    logic [4:0]  cmd_dev;
    logic [5:0]  cmd_reg;
    logic [7:0]  cmd_val;
    logic        cmd_all;
    logic [31:0] enc_frame;
    logic [31:0] chk_word;
    logic        chk_ok;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [31:0] rd_words [0:8];
    logic [31:0] tx_log [0:63];
    int n_tx = 0;
    int n_rd = 0;

    always #2.5 clk = ~clk;

    enum_chain_sequencer i_enum_chain_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .dev_count(dev_count), .err(err),
        .xfer_start(xfer_start), .xfer_tx(xfer_tx), .xfer_rx(xfer_rx),
        .xfer_done(xfer_done), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg),
        .cmd_val(cmd_val), .cmd_all(cmd_all), .enc_frame(enc_frame),
        .chk_word(chk_word), .chk_ok(chk_ok)
    );

    function automatic logic [7:0] crc8(input logic [21:0] d);
        logic [7:0] c = '0;
        for (int i = 21; i >= 0; i--) begin
            logic fb = c[7] ^ d[i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h2F;
        end
        return c;
    endfunction

    function automatic logic [4:0] rev5(input logic [4:0] a);
        return {a[0], a[1], a[2], a[3], a[4]};
    endfunction

    function automatic logic [31:0] frame(input logic [4:0] d, input logic [5:0] r,
                                          input logic [7:0] v, input logic a);
        logic [31:0] f = {d, r, v, a, 11'b0};
        f[10:3] = crc8({1'b0, f[31:11]});
        f[2:0]  = 3'b010;
        return f;
    endfunction

    function automatic logic good_crc(input logic [31:0] w);
        return crc8(w[31:10]) == w[9:2];
    endfunction

    // kind 0 good, 1 bad crc, 2 bad address
    function automatic logic [31:0] mk_word(input int n, input int kind);
        logic [31:0] w;
        logic [4:0]  a = rev5(5'(n));
        if (kind == 2) a = rev5(5'(n + 1));
        w = {a, 6'h0E, 8'($urandom), 3'b000, 10'b0};
        w[9:2] = crc8(w[31:10]);
        if (kind == 1) w[9:2] = ~w[9:2];
        return w;
    endfunction

    assign enc_frame = frame(cmd_dev, cmd_reg, cmd_val, cmd_all);
    assign chk_ok    = good_crc(chk_word);

    // transfer responder
    initial begin
        forever begin
            @(negedge clk);
            xfer_done = 1'b0;
            if (xfer_start) begin
                logic [31:0] resp = $urandom;
                if (n_tx < 64) tx_log[n_tx] = xfer_tx;
                n_tx++;
                if (xfer_tx == RDW) begin
                    resp = (n_rd < 9) ? rd_words[n_rd] : 32'h0;
                    n_rd++;
                end
                repeat (1 + $urandom % 4) @(negedge clk);
                xfer_rx   = resp;
                xfer_done = 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // independent model of the scan outcome
    task automatic model(output int e, output int cnt, output int reads);
        e = 3; cnt = 0; reads = 9;
        for (int n = 0; n < 9; n++) begin
            logic [31:0] w = rd_words[n];
            reads = n + 1;
            if (w == 0) begin
                if (n == 0) e = 3; else begin e = 0; cnt = n - 1; end
                return;
            end
            if (!good_crc(w)) begin e = 1; return; end
            if (rev5(w[31:27]) != 5'(n)) begin e = 2; return; end
        end
    endtask

    task automatic run_scan(input bit busy_start);
        int e, cnt, reads, waitc;
        model(e, cnt, reads);
        n_tx = 0; n_rd = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (busy_start) begin
            repeat (6) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        waitc = 0;
        while (!done && waitc < 2000) begin @(negedge clk); waitc++; end
        check(done, "R10 done seen", 32'(done), 1);
        check(err == 2'(e), (e == 0) ? "R5 err" : (e == 1) ? "R6 crc err" :
              (e == 2) ? "R7 addr err" : "R8 chain err", 32'(err), 32'(e));
        check(dev_count == 3'(cnt), "R5 dev_count", 32'(dev_count), 32'(cnt));
        check(tx_log[0] == frame(5'd0, 6'h0E, 8'h95, 1'b1), "R2 reset write", tx_log[0],
              frame(5'd0, 6'h0E, 8'h95, 1'b1));
        check(tx_log[1] == frame(5'd0, 6'h0E, 8'h15, 1'b1), "R2 release write", tx_log[1],
              frame(5'd0, 6'h0E, 8'h15, 1'b1));
        check(tx_log[2] == frame(5'd0, 6'h1C, 8'h38, 1'b1), "R3 pointer write", tx_log[2],
              frame(5'd0, 6'h1C, 8'h38, 1'b1));
        check(n_rd == reads, "R4 readback count", 32'(n_rd), 32'(reads));
        if (e != 0) begin
            check(n_tx == reads + 4, busy_start ? "R11 R9 transfer count" : "R9 transfer count",
                  32'(n_tx), 32'(reads + 4));
            check(tx_log[n_tx - 1] == frame(5'd0, 6'h0D, 8'h01, 1'b1), "R9 power-down write",
                  tx_log[n_tx - 1], frame(5'd0, 6'h0D, 8'h01, 1'b1));
        end else begin
            check(n_tx == reads + 3, busy_start ? "R11 transfer count" : "R5 no power-down",
                  32'(n_tx), 32'(reads + 3));
        end
        @(negedge clk);
        check(!done, "R10 done pulse", 32'(done), 0);
        check(err == 2'(e) && dev_count == 3'(cnt), "R10 result held",
              {27'b0, err, dev_count}, {27'b0, 2'(e), 3'(cnt)});
    endtask

    task automatic fill_chain(input int len, input int bad_idx, input int kind);
        for (int n = 0; n < 9; n++) begin
            if (n < len) rd_words[n] = mk_word(n, (n == bad_idx) ? kind : 0);
            else         rd_words[n] = 32'h0;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int n = 0; n < 9; n++) rd_words[n] = 0;
        repeat (3) @(negedge clk);
        check(!xfer_start && !done && err == 0 && dev_count == 0, "R1 reset state",
              {27'b0, xfer_start, done, err, 1'b0}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!xfer_start && !done, "R1 idle after reset", {30'b0, xfer_start, done}, 0);

        fill_chain(1, -1, 0); run_scan(0);          // R5 single device
        fill_chain(8, -1, 0); run_scan(0);          // R5 full chain
        fill_chain(0, -1, 0); run_scan(0);          // R8 empty chain
        fill_chain(9, -1, 0); run_scan(0);          // R8 no terminator
        fill_chain(4, 2, 1);  run_scan(0);          // R6 bad crc
        fill_chain(5, 0, 2);  run_scan(0);          // R7 bad address
        fill_chain(9, 8, 1);  run_scan(0);          // R6 on last word
        fill_chain(6, -1, 0); run_scan(1);          // R11 busy start

        for (int k = 0; k < 24; k++) begin
            int len  = 1 + $urandom % 9;
            int mode = $urandom % 3;
            fill_chain(len, (mode == 0) ? -1 : int'($urandom % len), mode);
            run_scan(k % 5 == 0);
        end
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            summary();
        end
    end

endmodule